// File: doc/BRIEF.md
# Timer Capture/Compare Channel

This block is one channel of a free-running timer. It takes the timer's count value and its overflow strobe from outside and is reached through a byte-wide register port. In capture mode the channel watches an input pin and, on a chosen edge, stores the full count value in its 16-bit data register and raises its event flag. In compare mode it compares the count against the data register. On a match it sets, clears or toggles its output pin and raises the event flag.

Software reaches the 16-bit data register one byte at a time, so the channel locks the register against the hardware while a byte pair is only half done. In capture mode, reading the high byte holds off new captures until the low byte has been read. In compare mode, writing the high byte holds off compare matches and the flag until the low byte has been written. For pulse-width modulation, a toggle-on-overflow option flips the pin at every counter wrap, and this wins over a match in the same cycle. A max-duty option drives the pin to a steady high. It starts and stops only at the overflow that follows the software change.

Top module: `tcc_channel`

## Requirements
- R1: After reset the control register (address 0) reads 0x00 and `pin_out` is 0. Control layout: bits [1:0] mode, [3:2] edge select, bit 4 toggle-on-overflow, bit 5 max-duty request, bit 7 event flag, bit 6 reads 0. Address 1 is the data register's high byte and address 2 is its low byte.
- R2: With mode 00 (capture), the edge select works as follows: 01 is rising, 10 is falling, 11 is both and 00 is none. A selected edge on `pin_in` (after `SYNC_STAGES` synchronizer flops) loads both data bytes with `cnt_val` in one cycle and sets the flag. An edge that is not selected changes neither.
- R3: In capture mode, a read of the high byte blocks all captures until the low byte is read. A second high-byte read keeps the block.
- R4: In compare mode, a write of the high byte blocks compare matches and the flag until the low byte is written.
- R5: In compare mode (mode non-zero), when `cnt_val` equals the data register, the pin takes an action on the next clock edge and the flag is set. Mode 01 toggles the pin, 10 clears it and 11 sets it.
- R6: The flag is cleared only by a write of the control register with bit 7 = 0 that comes after a control read which saw the flag set. Writing 0 without that read leaves it set.
- R7: With toggle-on-overflow set in compare mode, each `cnt_ovf` pulse toggles the pin. In capture mode the pin does not change, whatever toggle-on-overflow is set to.
- R8: When toggle-on-overflow is set and an overflow and a match fall in the same cycle, the pin toggles and the match action is not applied.
- R9: With toggle-on-overflow set, the max-duty request is copied to the active state at each `cnt_ovf`. While the active state is 1 the pin is held at 1. A change to the request therefore takes effect only after the next overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_val | input | 16 | Current timer count |
| cnt_ovf | input | 1 | One-cycle strobe when the counter wraps |
| pin_in | input | 1 | Capture input pin |
| pin_out | output | 1 | Compare/PWM output pin |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| chan_flag | output | 1 | Channel event flag |

## Verification
Capture runs with rising, falling and both-edge selects, and edges of the unselected polarity are sent to show that the select really filters. Each capture uses a distinct count value, so a stale or split byte pair is visible in the readback. This includes edges sent during a half-done high/low read. Compare runs through set, clear and toggle, and separately through overflow-only, match-only and overflow-plus-match cycles. A set action is used for the collision because it disagrees with a toggle from a high pin. The max-duty request is raised and dropped mid-period, and the pin is sampled before and after the following overflow to expose the one-period latency in both directions.

// File: rtl/tcc_pkg.sv
package tcc_pkg;
   // register addresses
   localparam int unsigned REG_CTRL = 0;
   localparam int unsigned REG_HI   = 1;
   localparam int unsigned REG_LO   = 2;

   // control bit positions
   localparam int unsigned CB_TOV  = 4;
   localparam int unsigned CB_MAX  = 5;
   localparam int unsigned CB_FLAG = 7;

   typedef enum logic [1:0] {
      MODE_CAPTURE = 2'b00,
      MODE_TOGGLE  = 2'b01,
      MODE_CLEAR   = 2'b10,
      MODE_SET     = 2'b11
   } mode_e;
endpackage

// File: rtl/tcc_pin_edge.sv
module tcc_pin_edge #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   output logic rise_o,
   output logic fall_o
);
   logic pin_s;
   logic pin_prev;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign pin_s = pin_i;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else if (SYNC_STAGES == 1) chain <= pin_i;
            else chain <= {chain[SYNC_STAGES-2:0], pin_i};
         end
         assign pin_s = chain[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pin_prev <= 1'b0;
      else        pin_prev <= pin_s;
   end

   assign rise_o = pin_s & ~pin_prev;
   assign fall_o = ~pin_s & pin_prev;
endmodule

// File: rtl/tcc_byte_lock.sv
module tcc_byte_lock (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic held_o,
   output logic block_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     held_o <= 1'b0;
      else if (set_i) held_o <= 1'b1;
      else if (clr_i) held_o <= 1'b0;
   end

   // a lock request blocks in the same cycle it arrives
   assign block_o = held_o | set_i;
endmodule

// File: rtl/tcc_out_ctl.sv
module tcc_out_ctl import tcc_pkg::*; (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  cmp_en_i,
   input  mode_e act_i,
   input  logic  tov_i,
   input  logic  ovf_i,
   input  logic  match_i,
   input  logic  max_req_i,
   output logic  max_act_o,
   output logic  pin_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pin_o     <= 1'b0;
         max_act_o <= 1'b0;
      end else begin
         if (ovf_i) max_act_o <= max_req_i;
         if (cmp_en_i) begin
            if (tov_i && max_act_o)  pin_o <= 1'b1;
            else if (tov_i && ovf_i) pin_o <= ~pin_o;
            else if (match_i) begin
               unique case (act_i)
                  MODE_TOGGLE: pin_o <= ~pin_o;
                  MODE_CLEAR:  pin_o <= 1'b0;
                  MODE_SET:    pin_o <= 1'b1;
                  default:     pin_o <= pin_o;
               endcase
            end
         end
      end
   end
endmodule

// File: rtl/tcc_channel.sv
module tcc_channel import tcc_pkg::*; #(
   parameter int unsigned CNT_W       = 16,
   parameter int unsigned BUS_W       = 8,
   parameter int unsigned ADDR_W      = 2,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CNT_W-1:0]  cnt_val,
   input  logic              cnt_ovf,
   input  logic              pin_in,
   output logic              pin_out,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   output logic              chan_flag
);
   localparam int unsigned HI_LSB = CNT_W - BUS_W;

   generate
      if (CNT_W != 2 * BUS_W) begin : g_bad_width
         $error("tcc_channel: CNT_W must be twice BUS_W");
      end
      if (BUS_W < 8) begin : g_bad_bus
         $error("tcc_channel: BUS_W must hold the 8 control bits");
      end
      if (ADDR_W < 2) begin : g_bad_addr
         $error("tcc_channel: ADDR_W must reach three registers");
      end
   endgenerate

   // register state
   mode_e            mode_q;
   logic [1:0]       edge_q;
   logic             tov_q;
   logic             max_req_q;
   logic             flag_q;
   logic             seen_q;
   logic [CNT_W-1:0] ch_q;

   // bus decode
   logic rd_acc, wr_acc, sel_ctrl, sel_hi, sel_lo;
   assign rd_acc   = bus_sel & ~bus_wr;
   assign wr_acc   = bus_sel & bus_wr;
   assign sel_ctrl = (bus_addr == ADDR_W'(REG_CTRL));
   assign sel_hi   = (bus_addr == ADDR_W'(REG_HI));
   assign sel_lo   = (bus_addr == ADDR_W'(REG_LO));

   logic cmp_en;
   assign cmp_en = (mode_q != MODE_CAPTURE);

   // coherency locks
   logic rd_held, rd_block, wr_held, wr_block;

   tcc_byte_lock u_rd_lock (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_i   (rd_acc & sel_hi & ~cmp_en),
      .clr_i   (rd_acc & sel_lo),
      .held_o  (rd_held),
      .block_o (rd_block)
   );

   tcc_byte_lock u_wr_lock (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_i   (wr_acc & sel_hi & cmp_en),
      .clr_i   (wr_acc & sel_lo),
      .held_o  (wr_held),
      .block_o (wr_block)
   );

   // capture path
   logic rise, fall, cap_evt, match_evt;

   tcc_pin_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_i  (pin_in),
      .rise_o (rise),
      .fall_o (fall)
   );

   assign cap_evt   = ~cmp_en & ~rd_block & ((edge_q[0] & rise) | (edge_q[1] & fall));
   assign match_evt = cmp_en & ~wr_block & (cnt_val == ch_q);

   // output control
   logic max_act;

   tcc_out_ctl u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmp_en_i  (cmp_en),
      .act_i     (mode_q),
      .tov_i     (tov_q),
      .ovf_i     (cnt_ovf),
      .match_i   (match_evt),
      .max_req_i (max_req_q),
      .max_act_o (max_act),
      .pin_o     (pin_out)
   );

   // control register and flag
   logic flag_clr;
   assign flag_clr = wr_acc & sel_ctrl & ~bus_wdata[CB_FLAG] & seen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q    <= MODE_CAPTURE;
         edge_q    <= 2'b00;
         tov_q     <= 1'b0;
         max_req_q <= 1'b0;
         flag_q    <= 1'b0;
         seen_q    <= 1'b0;
      end else begin
         if (wr_acc && sel_ctrl) begin
            mode_q    <= mode_e'(bus_wdata[1:0]);
            edge_q    <= bus_wdata[3:2];
            tov_q     <= bus_wdata[CB_TOV];
            max_req_q <= bus_wdata[CB_MAX];
         end
         if (cap_evt || match_evt) flag_q <= 1'b1;
         else if (flag_clr)        flag_q <= 1'b0;
         if (flag_clr)                        seen_q <= 1'b0;
         else if (rd_acc && sel_ctrl && flag_q) seen_q <= 1'b1;
      end
   end

   // data register: no reset value
   always_ff @(posedge clk) begin
      if (cap_evt) ch_q <= cnt_val;
      else if (wr_acc && sel_hi) ch_q[CNT_W-1:HI_LSB] <= bus_wdata;
      else if (wr_acc && sel_lo) ch_q[BUS_W-1:0]      <= bus_wdata;
   end

   // read mux
   always_comb begin
      bus_rdata = '0;
      if (sel_ctrl) begin
         bus_rdata[1:0]     = mode_q;
         bus_rdata[3:2]     = edge_q;
         bus_rdata[CB_TOV]  = tov_q;
         bus_rdata[CB_MAX]  = max_req_q;
         bus_rdata[CB_FLAG] = flag_q;
      end else if (sel_hi) begin
         bus_rdata = ch_q[CNT_W-1:HI_LSB];
      end else if (sel_lo) begin
         bus_rdata = ch_q[BUS_W-1:0];
      end
   end

   assign chan_flag = flag_q;
endmodule

// File: rtl/tcc_channel_chk.sv
module tcc_channel_chk #(
   parameter int unsigned CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cmp_en,
   input logic             tov_q,
   input logic             max_act,
   input logic             rd_held,
   input logic             wr_held,
   input logic             bus_sel,
   input logic             bus_wr,
   input logic             cnt_ovf,
   input logic             flag_q,
   input logic             pin_out,
   input logic [CNT_W-1:0] ch_q
);
   // R3
   rd_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cmp_en && rd_held && !(bus_sel && bus_wr)) |=> $stable(ch_q));

   // R4
   wr_lock_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_en && wr_held && !tov_q) |=> $stable(pin_out));

   // R4
   wr_lock_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_en && wr_held && !flag_q) |=> !flag_q);

   // R7
   cap_pin_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cmp_en |=> $stable(pin_out));

   // R8
   ovf_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_en && tov_q && !max_act && cnt_ovf) |=> (pin_out != $past(pin_out)));

   // R9
   max_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_en && tov_q && max_act) |=> pin_out);
endmodule

bind tcc_channel tcc_channel_chk #(.CNT_W(CNT_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .cmp_en  (cmp_en),
   .tov_q   (tov_q),
   .max_act (max_act),
   .rd_held (rd_held),
   .wr_held (wr_held),
   .bus_sel (bus_sel),
   .bus_wr  (bus_wr),
   .cnt_ovf (cnt_ovf),
   .flag_q  (flag_q),
   .pin_out (pin_out),
   .ch_q    (ch_q)
);

// File: tb/tb_tcc_channel.sv
module tb_tcc_channel;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cnt_val = 16'h0100;
   logic        cnt_ovf = 1'b0;
   logic        pin_in = 1'b0;
   logic        pin_out;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [1:0]  bus_addr = 2'd0;
   logic [7:0]  bus_wdata = 8'h00;
   logic [7:0]  bus_rdata;
   logic        chan_flag;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #5 clk = ~clk;

   tcc_channel dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .cnt_val   (cnt_val),
      .cnt_ovf   (cnt_ovf),
      .pin_in    (pin_in),
      .pin_out   (pin_out),
      .bus_sel   (bus_sel),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .chan_flag (chan_flag)
   );

   // scoreboard
   typedef struct {
      string       tag;
      logic [15:0] val;
   } exp_t;
   exp_t exp_q[$];

   task automatic push_exp(input string tag, input logic [15:0] val);
      exp_t e;
      e.tag = tag;
      e.val = val;
      exp_q.push_back(e);
   endtask

   task automatic pop_cmp(input logic [15:0] act);
      exp_t e;
      e = exp_q.pop_front();
      n_tests++;
      if (act !== e.val) begin
         n_fail++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", e.tag, act, e.val);
      end
   endtask

   // bus driver
   task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      @(posedge clk);
      #1 bus_sel = 1'b0;
   endtask

   task automatic bus_wrt(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      #1 bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd_chk(input logic [1:0] a, input string tag, input logic [7:0] ev);
      logic [7:0] d;
      push_exp(tag, {8'h00, ev});
      bus_rd(a, d);
      pop_cmp({8'h00, d});
   endtask

   task automatic pin_chk(input string tag, input logic ev);
      push_exp(tag, {15'd0, ev});
      @(negedge clk);
      pop_cmp({15'd0, pin_out});
   endtask

   // one cycle of counter stimulus, then back to an idle non-matching count
   task automatic tick(input logic [15:0] c, input logic o);
      @(negedge clk);
      cnt_val = c; cnt_ovf = o;
      @(posedge clk);
      @(negedge clk);
      cnt_val = 16'h0100; cnt_ovf = 1'b0;
   endtask

   task automatic drive_pin(input logic v);
      @(negedge clk);
      pin_in = v;
      repeat (4) @(posedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1 reset state
      rd_chk(2'd0, "R1 ctrl after reset", 8'h00);
      pin_chk("R1 pin after reset", 1'b0);

      // R2 rising capture
      bus_wrt(2'd0, 8'h04);
      cnt_val = 16'h1234;
      drive_pin(1'b1);
      rd_chk(2'd1, "R2 rise hi", 8'h12);
      rd_chk(2'd2, "R2 rise lo", 8'h34);
      rd_chk(2'd0, "R2 flag set", 8'h84);
      // R6 clear after a read that saw the flag
      bus_wrt(2'd0, 8'h04);
      rd_chk(2'd0, "R6 flag cleared", 8'h04);

      // R2 falling edge ignored with rising select
      cnt_val = 16'h5678;
      drive_pin(1'b0);
      rd_chk(2'd0, "R2 no flag on unselected edge", 8'h04);
      rd_chk(2'd1, "R2 unselected hi", 8'h12);
      rd_chk(2'd2, "R2 unselected lo", 8'h34);

      // R2 falling select
      bus_wrt(2'd0, 8'h08);
      drive_pin(1'b1);
      drive_pin(1'b0);
      rd_chk(2'd1, "R2 fall hi", 8'h56);
      rd_chk(2'd2, "R2 fall lo", 8'h78);

      // R6 write 0 without prior read keeps the flag
      bus_wrt(2'd0, 8'h0C);
      rd_chk(2'd0, "R6 flag kept", 8'h8C);
      bus_wrt(2'd0, 8'h0C);
      rd_chk(2'd0, "R6 flag cleared both", 8'h0C);

      // R3 capture lock
      rd_chk(2'd1, "R3 locked hi", 8'h56);
      cnt_val = 16'h9ABC;
      drive_pin(1'b1);
      rd_chk(2'd1, "R3 second hi read", 8'h56);
      drive_pin(1'b0);
      rd_chk(2'd2, "R3 lo after lock", 8'h78);
      rd_chk(2'd0, "R3 no flag while locked", 8'h0C);
      drive_pin(1'b1);
      rd_chk(2'd1, "R3 capture after unlock hi", 8'h9A);
      rd_chk(2'd2, "R3 capture after unlock lo", 8'hBC);

      // R5 compare actions, compare value 0x0020
      bus_wrt(2'd1, 8'h00);
      bus_wrt(2'd2, 8'h20);
      rd_chk(2'd0, "R2 flag from last capture", 8'h8C);
      bus_wrt(2'd0, 8'h03);
      tick(16'h0020, 1'b0);
      pin_chk("R5 set on match", 1'b1);
      rd_chk(2'd0, "R5 flag on match", 8'h83);
      bus_wrt(2'd0, 8'h02);
      tick(16'h0020, 1'b0);
      pin_chk("R5 clear on match", 1'b0);
      bus_wrt(2'd0, 8'h01);
      tick(16'h0020, 1'b0);
      pin_chk("R5 toggle on match a", 1'b1);
      tick(16'h0020, 1'b0);
      pin_chk("R5 toggle on match b", 1'b0);

      // R4 compare lock
      rd_chk(2'd0, "R5 flag toggle mode", 8'h81);
      bus_wrt(2'd0, 8'h03);
      bus_wrt(2'd1, 8'h00);
      tick(16'h0020, 1'b0);
      pin_chk("R4 no match while locked", 1'b0);
      rd_chk(2'd0, "R4 no flag while locked", 8'h03);
      bus_wrt(2'd2, 8'h20);
      tick(16'h0020, 1'b0);
      pin_chk("R4 match after unlock", 1'b1);
      rd_chk(2'd0, "R4 flag after unlock", 8'h83);

      // R7 overflow toggle ignored in capture mode
      bus_wrt(2'd0, 8'h10);
      tick(16'h0100, 1'b1);
      pin_chk("R7 capture mode ovf a", 1'b1);
      tick(16'h0100, 1'b1);
      pin_chk("R7 capture mode ovf b", 1'b1);

      // R7 overflow toggle in compare mode
      bus_wrt(2'd0, 8'h13);
      tick(16'h0100, 1'b1);
      pin_chk("R7 ovf toggle a", 1'b0);
      tick(16'h0100, 1'b1);
      pin_chk("R7 ovf toggle b", 1'b1);

      // R8 overflow beats set-on-match
      tick(16'h0020, 1'b1);
      pin_chk("R8 overflow wins", 1'b0);

      // R9 max duty latency
      bus_wrt(2'd0, 8'h32);
      tick(16'h0020, 1'b0);
      pin_chk("R9 not active before ovf", 1'b0);
      tick(16'h0100, 1'b1);
      pin_chk("R9 ovf toggles", 1'b1);
      tick(16'h0020, 1'b0);
      pin_chk("R9 forced high over clear", 1'b1);
      bus_wrt(2'd0, 8'h12);
      tick(16'h0020, 1'b0);
      pin_chk("R9 still forced after request drop", 1'b1);
      tick(16'h0100, 1'b1);
      pin_chk("R9 forced through ovf", 1'b1);
      tick(16'h0020, 1'b0);
      pin_chk("R9 released after ovf", 1'b0);

      finish_run();
   end
endmodule